// File: doc/BRIEF.md
# Condition-Code Branch and Link Unit

This unit executes two four-byte control-transfer instructions for a processor pipeline. A conditional branch compares the current 2-bit condition code against a 4-bit mask carried in the high nibble of the instruction's second byte. It moves the program counter to a precomputed target when the mask selects the present code, and to the sequential address otherwise. A branch-with-link always jumps. It also hands the sequential address to a general register, which the high nibble of the second byte names, so that a called routine can return through that register.

The pipeline presents the opcode byte, the control byte, the condition code, the already computed target and the sequential next address together with a valid strobe. One clock later the unit presents the new program counter, a register write request and a specification-error flag, all in the same cycle and for one cycle only. Address arithmetic, instruction fetch and the register file belong to other blocks.

Top module: `cc_branch_unit`

## Requirements
- R1: An instruction is accepted when `instr_valid` is 1 and `instr_op` equals `OP_COND` (default 8'hC4) or `OP_LINK` (default 8'hC5). Its results appear on the outputs in the next cycle, with `pc_valid` 1 for that one cycle. Any other opcode leaves every output at 0.
- R2: For a conditional branch, control bit 7 selects condition code 0, bit 6 selects code 1, bit 5 selects code 2 and bit 4 selects code 3. When the bit for the current code is 1, `branch_taken` is 1 and `pc_next` equals the `target_addr` of the accepted instruction.
- R3: A conditional branch whose selected mask bit is 0 gives `branch_taken` 0 and `pc_next` equal to the accepted `seq_addr`.
- R4: The control byte 8'hF0 branches for every condition code.
- R5: A control byte of 8'h00 never branches, for any condition code.
- R6: A conditional branch whose control bits 3..0 are not all zero raises `spec_err` for exactly one cycle. The branch is suppressed, so `branch_taken` is 0 and `pc_next` is `seq_addr`. No register write takes place.
- R7: A branch-with-link is taken for every condition code. In the same cycle as `pc_next` = `target_addr`, it gives `reg_we` 1, `reg_idx` equal to control bits 7..4 (any of registers 0 to 15) and `reg_wdata` equal to `seq_addr`. Its control bits 3..0 are ignored and raise no `spec_err`.
- R8: A conditional branch never requests a register write.
- R9: While `rst_n` is 0 and after reset, every output is 0 until an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction bytes and operands are present |
| instr_op | input | 8 | First instruction byte (opcode) |
| instr_ctl | input | 8 | Second instruction byte (mask or register field) |
| cond_code | input | 2 | Current condition code |
| target_addr | input | ADDR_W | Precomputed branch target |
| seq_addr | input | ADDR_W | Address of the following instruction |
| pc_valid | output | 1 | New program counter is valid this cycle |
| pc_next | output | ADDR_W | New program counter |
| branch_taken | output | 1 | Control moved to the target |
| reg_we | output | 1 | Link register write request |
| reg_idx | output | 4 | Link register number |
| reg_wdata | output | ADDR_W | Link value (sequential address) |
| spec_err | output | 1 | Malformed conditional mask |

## Verification
On every cycle the assertions check several relations. A taken branch carries the target of the previous cycle. A link write carries the previous sequential address. A specification error never goes with a jump or a write. The all-ones mask always jumps, the empty mask never does, and a link is never untaken. The bench's scenarios are needed for the rest. They cover the bit-to-code ordering of the mask across all four codes, the register numbers at the edges of the range, and the one-cycle length of the error pulse. They also show that unknown opcodes and the link's low nibble are ignored at the ports.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_COND = 2'd1,
        KIND_LINK = 2'd2
    } instr_kind_e;
endpackage

// File: rtl/cbl_decode.sv
module cbl_decode
    import cbl_pkg::*;
#(
    parameter int          CTL_W   = 8,
    parameter logic [7:0]  OP_COND = 8'hC4,
    parameter logic [7:0]  OP_LINK = 8'hC5,
    localparam int         FIELD_W = CTL_W / 2
) (
    input  logic               valid_i,
    input  logic [7:0]         op_i,
    input  logic [CTL_W-1:0]   ctl_i,
    output instr_kind_e        kind_o,
    output logic [FIELD_W-1:0] field_o,
    output logic               low_bad_o
);
    always_comb begin
        kind_o = KIND_NONE;
        if (valid_i) begin
            if (op_i == OP_COND)      kind_o = KIND_COND;
            else if (op_i == OP_LINK) kind_o = KIND_LINK;
        end
    end

    assign field_o   = ctl_i[CTL_W-1:FIELD_W];
    assign low_bad_o = |ctl_i[FIELD_W-1:0];
endmodule

// File: rtl/cbl_mask_match.sv
module cbl_mask_match #(
    parameter int  N_CC = 4,
    localparam int CC_W = $clog2(N_CC)
) (
    input  logic [N_CC-1:0] mask_i,
    input  logic [CC_W-1:0] cc_i,
    output logic            hit_o
);
    logic [N_CC-1:0] sel;

    // leftmost mask bit belongs to code 0
    for (genvar i = 0; i < N_CC; i++) begin : g_code
        assign sel[i] = mask_i[N_CC-1-i] & (cc_i == CC_W'(i));
    end

    assign hit_o = |sel;
endmodule

// File: rtl/cbl_pc_select.sv
module cbl_pc_select #(
    parameter int ADDR_W = 24
) (
    input  logic              take_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] seq_i,
    output logic [ADDR_W-1:0] pc_o
);
    assign pc_o = take_i ? target_i : seq_i;
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cbl_pkg::*;
#(
    parameter int         ADDR_W  = 24,
    parameter int         CTL_W   = 8,
    parameter logic [7:0] OP_COND = 8'hC4,
    parameter logic [7:0] OP_LINK = 8'hC5,
    localparam int        FIELD_W = CTL_W / 2,
    localparam int        CC_W    = $clog2(FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [7:0]         instr_op,
    input  logic [CTL_W-1:0]   instr_ctl,
    input  logic [CC_W-1:0]    cond_code,
    input  logic [ADDR_W-1:0]  target_addr,
    input  logic [ADDR_W-1:0]  seq_addr,
    output logic               pc_valid,
    output logic [ADDR_W-1:0]  pc_next,
    output logic               branch_taken,
    output logic               reg_we,
    output logic [FIELD_W-1:0] reg_idx,
    output logic [ADDR_W-1:0]  reg_wdata,
    output logic               spec_err
);
    typedef struct packed {
        logic               pc_valid;
        logic [ADDR_W-1:0]  pc;
        logic               taken;
        logic               we;
        logic [FIELD_W-1:0] idx;
        logic [ADDR_W-1:0]  wdata;
        logic               spec_err;
    } out_state_t;

    instr_kind_e        kind;
    logic [FIELD_W-1:0] field;
    logic               low_bad;
    logic               mask_hit;
    logic               take;
    logic [ADDR_W-1:0]  pc_sel;
    out_state_t         st_d, st_q;

    cbl_decode #(
        .CTL_W   (CTL_W),
        .OP_COND (OP_COND),
        .OP_LINK (OP_LINK)
    ) u_decode (
        .valid_i   (instr_valid),
        .op_i      (instr_op),
        .ctl_i     (instr_ctl),
        .kind_o    (kind),
        .field_o   (field),
        .low_bad_o (low_bad)
    );

    cbl_mask_match #(.N_CC(FIELD_W)) u_match (
        .mask_i (field),
        .cc_i   (cond_code),
        .hit_o  (mask_hit)
    );

    always_comb begin
        unique case (kind)
            KIND_COND: take = mask_hit && !low_bad;
            KIND_LINK: take = 1'b1;
            default:   take = 1'b0;
        endcase
    end

    cbl_pc_select #(.ADDR_W(ADDR_W)) u_pcsel (
        .take_i   (take),
        .target_i (target_addr),
        .seq_i    (seq_addr),
        .pc_o     (pc_sel)
    );

    always_comb begin
        st_d          = '0;
        st_d.pc_valid = (kind != KIND_NONE);
        st_d.taken    = take;
        if (kind != KIND_NONE) st_d.pc = pc_sel;
        if (kind == KIND_LINK) begin
            st_d.we    = 1'b1;
            st_d.idx   = field;
            st_d.wdata = seq_addr;
        end
        if (kind == KIND_COND) st_d.spec_err = low_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_valid     = st_q.pc_valid;
    assign pc_next      = st_q.pc;
    assign branch_taken = st_q.taken;
    assign reg_we       = st_q.we;
    assign reg_idx      = st_q.idx;
    assign reg_wdata    = st_q.wdata;
    assign spec_err     = st_q.spec_err;

    AST_TAKEN_GOES_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> (pc_valid && pc_next == $past(target_addr))); // R2
    AST_LINK_DATA_IS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (branch_taken && reg_wdata == $past(seq_addr))); // R7
    AST_SPEC_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> (!branch_taken && !reg_we && pc_next == $past(seq_addr))); // R6
    AST_ALL_ONES_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_valid && instr_op == OP_COND && instr_ctl == 8'hF0))
        |-> branch_taken); // R4
    AST_EMPTY_MASK_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_valid && instr_op == OP_COND && instr_ctl == 8'h00))
        |-> (!branch_taken && pc_valid)); // R5
    AST_NO_OUTPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |-> (!branch_taken && !reg_we && !spec_err)); // R1
    AST_WRITE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, spec_err})); // R8
endmodule

// File: tb/sim_cc_branch_unit.sv
module sim_cc_branch_unit;
    localparam int AW = 24;
    localparam logic [7:0] OPC = 8'hC4;
    localparam logic [7:0] OPL = 8'hC5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [7:0]    instr_op = '0;
    logic [7:0]    instr_ctl = '0;
    logic [1:0]    cond_code = '0;
    logic [AW-1:0] target_addr = '0;
    logic [AW-1:0] seq_addr = '0;
    logic          pc_valid, branch_taken, reg_we, spec_err;
    logic [AW-1:0] pc_next, reg_wdata;
    logic [3:0]    reg_idx;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    cc_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_ctl(instr_ctl), .cond_code(cond_code), .target_addr(target_addr),
        .seq_addr(seq_addr), .pc_valid(pc_valid), .pc_next(pc_next),
        .branch_taken(branch_taken), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .spec_err(spec_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // present one instruction, return with its results on the outputs
    task automatic issue(input logic [7:0] op, input logic [7:0] ctl, input logic [1:0] cc,
                         input logic [AW-1:0] tgt, input logic [AW-1:0] seq);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_ctl = ctl;
        cond_code = cc; target_addr = tgt; seq_addr = seq;
        @(negedge clk);
        instr_valid = 1'b0;
        target_addr = ~tgt; seq_addr = ~seq;
    endtask

    task automatic expect_cond(input string req, input logic [7:0] ctl, input logic [1:0] cc,
                               input logic [AW-1:0] tgt, input logic [AW-1:0] seq);
        logic tk;
        tk = (ctl[3:0] == 4'h0) && ctl[7 - int'(cc)];
        chk(req, "pc_valid", 32'(pc_valid), 32'd1);
        chk(req, "taken", 32'(branch_taken), 32'(tk));
        chk(req, "pc_next", 32'(pc_next), 32'(tk ? tgt : seq));
        chk("R8", "reg_we on cond", 32'(reg_we), 32'd0);
    endtask

    task automatic t_reset();
        chk("R9", "pc_valid", 32'(pc_valid), 0);
        chk("R9", "taken", 32'(branch_taken), 0);
        chk("R9", "reg_we", 32'(reg_we), 0);
        chk("R9", "spec_err", 32'(spec_err), 0);
        chk("R9", "pc_next", 32'(pc_next), 0);
    endtask

    task automatic t_mask_order();
        for (int c = 0; c < 4; c++) begin
            logic [7:0] m;
            m = 8'h80 >> c;
            issue(OPC, m, 2'(c), 24'h0A0000 + 24'(c), 24'h000104);
            expect_cond("R2", m, 2'(c), 24'h0A0000 + 24'(c), 24'h000104);
            issue(OPC, ~m & 8'hF0, 2'(c), 24'h0B0000, 24'h000208 + 24'(c));
            expect_cond("R3", ~m & 8'hF0, 2'(c), 24'h0B0000, 24'h000208 + 24'(c));
            issue(OPC, 8'hA0, 2'(c), 24'h123456, 24'h654320);
            expect_cond("R2", 8'hA0, 2'(c), 24'h123456, 24'h654320);
        end
    endtask

    task automatic t_uncond();
        for (int c = 0; c < 4; c++) begin
            issue(OPC, 8'hF0, 2'(c), 24'hFFFFF0, 24'h000010);
            chk("R4", "taken", 32'(branch_taken), 1);
            chk("R4", "pc_next", 32'(pc_next), 32'h00FFFFF0);
        end
    endtask

    task automatic t_never();
        for (int c = 0; c < 4; c++) begin
            issue(OPC, 8'h00, 2'(c), 24'h777770, 24'h000020);
            chk("R5", "taken", 32'(branch_taken), 0);
            chk("R5", "pc_next", 32'(pc_next), 32'h00000020);
        end
    endtask

    task automatic t_spec();
        issue(OPC, 8'hF1, 2'd0, 24'h440000, 24'h000030);
        chk("R6", "spec_err", 32'(spec_err), 1);
        chk("R6", "taken", 32'(branch_taken), 0);
        chk("R6", "pc_next", 32'(pc_next), 32'h00000030);
        chk("R6", "reg_we", 32'(reg_we), 0);
        @(negedge clk);
        chk("R6", "spec_err one cycle", 32'(spec_err), 0);
        issue(OPC, 8'h88, 2'd0, 24'h440000, 24'h000034);
        chk("R6", "spec_err 88", 32'(spec_err), 1);
        chk("R6", "taken 88", 32'(branch_taken), 0);
    endtask

    task automatic t_link();
        logic [3:0] regs [4] = '{4'd0, 4'd10, 4'd15, 4'd7};
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ctl;
            ctl = {regs[k], (k == 3) ? 4'hB : 4'h0};
            issue(OPL, ctl, 2'(k), 24'h200000 + 24'(k), 24'h000400 + 24'(k * 4));
            chk("R7", "taken", 32'(branch_taken), 1);
            chk("R7", "pc_next", 32'(pc_next), 32'h00200000 + 32'(k));
            chk("R7", "reg_we", 32'(reg_we), 1);
            chk("R7", "reg_idx", 32'(reg_idx), 32'(regs[k]));
            chk("R7", "reg_wdata", 32'(reg_wdata), 32'h00000400 + 32'(k * 4));
            chk("R7", "no spec_err", 32'(spec_err), 0);
        end
    endtask

    task automatic t_other_op();
        issue(8'h47, 8'hF0, 2'd1, 24'h111110, 24'h000040);
        chk("R1", "pc_valid other op", 32'(pc_valid), 0);
        chk("R1", "taken other op", 32'(branch_taken), 0);
        chk("R1", "reg_we other op", 32'(reg_we), 0);
        issue(OPC, 8'hF0, 2'd1, 24'h111110, 24'h000040);
        @(negedge clk);
        chk("R1", "pc_valid one cycle", 32'(pc_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_order();
        t_uncond();
        t_never();
        t_spec();
        t_link();
        t_other_op();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule